// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Processor Core

This block is a small multi-cycle processor. It has sixteen 8-bit general registers, an 8-bit program counter and a 256-byte memory that holds both code and data. Each instruction is 16 bits wide. The top four bits select the operation and the low twelve bits carry register numbers, an 8-bit address or immediate, or a 12-bit delay. The core runs one instruction at a time in three steps: a high-byte fetch, a low-byte fetch, then execute. It stays in execute for more cycles only when a delay is requested.

The memory lives inside the block. A load port writes bytes into it, and a peek port reads any byte combinationally, so a bench or the surrounding logic can place a program and read back its results. The floating-point add is not built into the core. The core presents the two source registers on a pair of output buses and takes the sum back on an input bus in the same cycle, so any combinational adder can be attached outside. The delay length is set by a clock-cycles-per-millisecond parameter.

Top module: `byte_cpu`

## Requirements
- R1: A reset (rst_n low at a clock edge) sets the program counter to 0x00, clears the halted flag and clears all sixteen registers to zero. Memory contents are not affected.
- R2: Each instruction is fetched from two consecutive bytes. The byte at the program counter becomes bits [15:12] opcode and [11:8], the byte at PC+1 becomes bits [7:0], and PC then advances by 2 modulo 256. An instruction without a delay occupies exactly 3 clock cycles.
- R3: Opcode 0x1 (fields R=[11:8], XY=[7:0]) loads R from memory[XY]. Opcode 0x2 loads R with the value XY. Opcode 0x3 stores R to memory[XY]. Opcode 0x4 copies the register named in [7:4] into the register named in [3:0], ignoring bits [11:8].
- R4: Opcode 0x5 writes (S + T) mod 256 into R, where S=[7:4] and T=[3:0] are register numbers.
- R5: Opcodes 0x7, 0x8 and 0x9 write the bitwise OR, AND and XOR of registers S and T into R.
- R6: Opcode 0xA rotates register R right by the amount in bits [3:0] taken modulo 8.
- R7: Opcode 0xB sets PC to XY when register R equals register 0. Otherwise PC keeps the sequential value.
- R8: Opcode 0xC raises halted. After that, PC, registers and memory no longer change until the next reset.
- R9: Opcode 0xD stalls for exactly operand[11:0] × CYC_PER_MS extra clock cycles before the next fetch. An operand of zero adds no cycles.
- R10: Opcode 0xE writes register R ([11:8]) to the memory address held in register T ([3:0]), ignoring bits [7:4].
- R11: Opcode 0x6 drives register S on fp_a and register T on fp_b, and writes fp_sum into R.
- R12: Opcodes 0x0 and 0xF change no register and no memory byte, and take 3 cycles like any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write load_data into memory this cycle |
| load_addr | input | 8 | Memory address for a load-port write |
| load_data | input | 8 | Byte written by the load port |
| peek_addr | input | 8 | Memory address read combinationally |
| peek_data | output | 8 | Memory byte at peek_addr |
| fp_a | output | 8 | First floating-point operand (register S) |
| fp_b | output | 8 | Second floating-point operand (register T) |
| fp_sum | input | 8 | Result from the external floating-point adder |
| pc | output | 8 | Current program counter |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The arithmetic and logic operations are swept over a grid of operand pairs. The grid includes pairs whose sum wraps past 255, which separates a modulo add from a saturating or widened one. A pairwise nibble-swapping stand-in adder is attached to the floating-point port; because it is not symmetric, swapped fp_a and fp_b buses show up. Rotates are run for every amount from 0 to 15 on two seed values, which exposes left-for-right mistakes and counts that are not reduced modulo 8. Short programs cover the rest:
- a jump that is taken and a jump that is not, including one that lands at 0xFE and wraps the fetch past 0xFF;
- register-indirect stores and register moves with junk in the unused fields;
- no-op opcodes;
- delays of zero, two and nineteen milliseconds, each checked by counting cycles to the halt.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;

   localparam int INSN_W = 16;
   localparam int OPC_W  = 4;
   localparam int MS_W   = 12;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP  = 4'h0,
      OP_LDM  = 4'h1,
      OP_LDI  = 4'h2,
      OP_STM  = 4'h3,
      OP_MOV  = 4'h4,
      OP_ADD  = 4'h5,
      OP_FADD = 4'h6,
      OP_OR   = 4'h7,
      OP_AND  = 4'h8,
      OP_XOR  = 4'h9,
      OP_ROR  = 4'hA,
      OP_JEQ  = 4'hB,
      OP_HALT = 4'hC,
      OP_WAIT = 4'hD,
      OP_STI  = 4'hE,
      OP_RSV  = 4'hF
   } op_t;

   typedef enum logic [2:0] {
      ST_FETCH_HI,
      ST_FETCH_LO,
      ST_EXEC,
      ST_WAIT,
      ST_HALT
   } cpu_state_t;

endpackage

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile #(
   parameter int DATA_W = 8,
   parameter int REG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [REG_AW-1:0] ra,
   input  logic [REG_AW-1:0] rb,
   input  logic [REG_AW-1:0] rc,
   output logic [DATA_W-1:0] qa,
   output logic [DATA_W-1:0] qb,
   output logic [DATA_W-1:0] qc,
   output logic [DATA_W-1:0] q0
);
   localparam int NREG = 1 << REG_AW;

   logic [DATA_W-1:0] regs_q [NREG];
   logic [NREG-1:0]   hit;

   for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign hit[i] = we && (waddr == REG_AW'(i));
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREG; i++) begin
         if (!rst_n)      regs_q[i] <= '0;
         else if (hit[i]) regs_q[i] <= wdata;
      end
   end

   assign qa = regs_q[ra];
   assign qb = regs_q[rb];
   assign qc = regs_q[rc];
   assign q0 = regs_q[0];

   // register 0 only moves when it is the write target
   p_reg0_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == '0) |=> $stable(q0));

endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
   import byte_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int REG_AW = 4
) (
   input  op_t               opc,
   input  logic [REG_AW-1:0] f_r,
   input  logic [REG_AW-1:0] f_t,
   input  logic [DATA_W-1:0] r_val,
   input  logic [DATA_W-1:0] s_val,
   input  logic [DATA_W-1:0] t_val,
   input  logic [DATA_W-1:0] xy,
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] fp_val,
   output logic              wr_en,
   output logic [REG_AW-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int RA_W = $clog2(DATA_W);

   logic [RA_W-1:0]     rot_amt;
   logic [2*DATA_W-1:0] rot_dbl;

   assign rot_amt = f_t[RA_W-1:0];
   assign rot_dbl = {r_val, r_val} >> rot_amt;

   always_comb begin
      wr_en   = 1'b1;
      wr_addr = f_r;
      wr_data = '0;
      case (opc)
         OP_LDM:  wr_data = mem_val;
         OP_LDI:  wr_data = xy;
         OP_MOV:  begin wr_addr = f_t; wr_data = s_val; end
         OP_ADD:  wr_data = s_val + t_val;
         OP_FADD: wr_data = fp_val;
         OP_OR:   wr_data = s_val | t_val;
         OP_AND:  wr_data = s_val & t_val;
         OP_XOR:  wr_data = s_val ^ t_val;
         OP_ROR:  wr_data = rot_dbl[DATA_W-1:0];
         default: wr_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/byte_cpu_wait_timer.sv
module byte_cpu_wait_timer #(
   parameter int MS_W       = 12,
   parameter int CYC_PER_MS = 100000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [MS_W-1:0] ms,
   output logic            busy,
   output logic            last
);
   localparam longint MAX_CYC = ((longint'(1) << MS_W) - 1) * longint'(CYC_PER_MS);
   localparam int     CW      = $clog2(MAX_CYC + 1);
   localparam logic [CW-1:0] CPM_V = CW'(CYC_PER_MS);

   initial begin
      assert (CYC_PER_MS >= 1) else $error("CYC_PER_MS must be at least 1");
      assert (CW >= MS_W) else $error("timer narrower than its operand");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (start)        cnt_q <= CW'(ms) * CPM_V;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == CW'(1));

   p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
   p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
   import byte_cpu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 8,
   parameter int REG_AW     = 4,
   parameter int CYC_PER_MS = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data,
   output logic [DATA_W-1:0] fp_a,
   output logic [DATA_W-1:0] fp_b,
   input  logic [DATA_W-1:0] fp_sum,
   output logic [ADDR_W-1:0] pc,
   output logic              halted
);
   localparam int MEM_DEPTH = 1 << ADDR_W;

   initial begin
      assert (DATA_W == 8 && ADDR_W == 8 && REG_AW == 4)
         else $error("instruction format fixes byte, address and register widths");
      assert (2 * DATA_W == INSN_W) else $error("instruction must be two bytes");
   end

   cpu_state_t        state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [INSN_W-1:0] ir_q;
   logic [DATA_W-1:0] mem_q [MEM_DEPTH];

   op_t               opc;
   logic              exec;
   logic [DATA_W-1:0] r_val, s_val, t_val, reg0, mem_val;
   logic              rf_we, alu_we;
   logic [REG_AW-1:0] rf_waddr;
   logic [DATA_W-1:0] rf_wdata;
   logic              st_we;
   logic [ADDR_W-1:0] st_addr;
   logic              tm_start, tm_busy, tm_last;
   logic              jmp_take;

   assign opc      = op_t'(ir_q[INSN_W-1 -: OPC_W]);
   assign exec     = (state_q == ST_EXEC);
   assign mem_val  = mem_q[ir_q[ADDR_W-1:0]];
   assign jmp_take = (r_val == reg0);

   byte_cpu_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
      .ra(ir_q[11:8]), .rb(ir_q[7:4]), .rc(ir_q[3:0]),
      .qa(r_val), .qb(s_val), .qc(t_val), .q0(reg0)
   );

   byte_cpu_alu #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_alu (
      .opc(opc), .f_r(ir_q[11:8]), .f_t(ir_q[3:0]),
      .r_val(r_val), .s_val(s_val), .t_val(t_val),
      .xy(ir_q[7:0]), .mem_val(mem_val), .fp_val(fp_sum),
      .wr_en(alu_we), .wr_addr(rf_waddr), .wr_data(rf_wdata)
   );

   assign rf_we    = exec && alu_we;
   assign tm_start = exec && (opc == OP_WAIT) && (ir_q[MS_W-1:0] != '0);

   byte_cpu_wait_timer #(.MS_W(MS_W), .CYC_PER_MS(CYC_PER_MS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tm_start), .ms(ir_q[MS_W-1:0]),
      .busy(tm_busy), .last(tm_last)
   );

   // memory: load port has priority over stores from the program
   assign st_we   = exec && (opc == OP_STM || opc == OP_STI);
   assign st_addr = (opc == OP_STI) ? ADDR_W'(t_val) : ir_q[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (load_en)    mem_q[load_addr] <= load_data;
      else if (st_we) mem_q[st_addr]   <= r_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_FETCH_HI;
         pc_q    <= '0;
         ir_q    <= '0;
      end else begin
         case (state_q)
            ST_FETCH_HI: begin
               ir_q[INSN_W-1:DATA_W] <= mem_q[pc_q];
               state_q <= ST_FETCH_LO;
            end
            ST_FETCH_LO: begin
               ir_q[DATA_W-1:0] <= mem_q[pc_q + 1'b1];
               pc_q    <= pc_q + ADDR_W'(2);
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               state_q <= ST_FETCH_HI;
               case (opc)
                  OP_JEQ:  if (jmp_take) pc_q <= ir_q[ADDR_W-1:0];
                  OP_HALT: state_q <= ST_HALT;
                  OP_WAIT: if (tm_start) state_q <= ST_WAIT;
                  default: ;
               endcase
            end
            ST_WAIT:  if (tm_last) state_q <= ST_FETCH_HI;
            default:  state_q <= ST_HALT;
         endcase
      end
   end

   assign pc        = pc_q;
   assign halted    = (state_q == ST_HALT);
   assign peek_data = mem_q[peek_addr];
   assign fp_a      = s_val;
   assign fp_b      = t_val;

   p_jump_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && opc == OP_JEQ && r_val == reg0) |=> (pc_q == $past(ir_q[7:0])));
   p_jump_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && opc == OP_JEQ && r_val != reg0) |=> $stable(pc_q));
   p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc_q)));
   p_halt_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !rf_we);
   p_wait_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> tm_busy);

endmodule

// File: tb/byte_cpu_bench.sv
`timescale 1ns/1ps
module byte_cpu_bench;
   localparam int CPM = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0;
   logic [7:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic [7:0] peek_addr = '0;
   logic [7:0] peek_data, fp_a, fp_b, fp_sum, pc;
   logic       halted;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   // asymmetric stand-in for the external adder
   assign fp_sum = fp_a + {fp_b[3:0], fp_b[7:4]};

   byte_cpu #(.CYC_PER_MS(CPM)) u_byte_cpu (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
      .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
      .fp_a(fp_a), .fp_b(fp_b), .fp_sum(fp_sum), .pc(pc), .halted(halted)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic poke(input int a, input int d);
      load_en   = 1'b1;
      load_addr = 8'(a);
      load_data = 8'(d);
      @(negedge clk);
   endtask

   task automatic put(input int a, input int w);
      poke(a, (w >> 8) & 255);
      poke((a + 1) & 255, w & 255);
   endtask

   task automatic begin_prog();
      rst_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 256; i++) poke(i, 255);
   endtask

   task automatic go(output int cyc);
      load_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      while (!halted && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic peek(input int a, output int v);
      peek_addr = 8'(a);
      #0.5;
      v = int'(peek_data);
   endtask

   function automatic int rot(input int v, input int k);
      int m;
      m = k % 8;
      return ((v >> m) | (v << (8 - m))) & 255;
   endfunction

   initial begin
      int cyc, v, a, b;
      // ---------------- ALU sweep: R4, R5, R11, R2
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            a = (i * 23 + 5) & 255;
            b = (j * 37 + 200) & 255;
            begin_prog();
            if (i == 0 && j == 0) begin
               chk("R1", "pc in reset", int'(pc), 0);
               chk("R1", "halted in reset", int'(halted), 0);
            end
            put(8'h00, 16'h2100 | a);
            put(8'h02, 16'h2200 | b);
            put(8'h04, 16'h5312);
            put(8'h06, 16'h7412);
            put(8'h08, 16'h8512);
            put(8'h0A, 16'h9612);
            put(8'h0C, 16'h6712);
            put(8'h0E, 16'h3380);
            put(8'h10, 16'h3481);
            put(8'h12, 16'h3582);
            put(8'h14, 16'h3683);
            put(8'h16, 16'h3784);
            put(8'h18, 16'hC000);
            go(cyc);
            chk("R2", "cycles for 13 instructions", cyc, 39);
            peek(8'h80, v); chk("R4", "add mod 256", v, (a + b) & 255);
            peek(8'h81, v); chk("R5", "or", v, a | b);
            peek(8'h82, v); chk("R5", "and", v, a & b);
            peek(8'h83, v); chk("R5", "xor", v, a ^ b);
            peek(8'h84, v); chk("R11", "fp result", v,
                                (a + (((b & 15) << 4) | (b >> 4))) & 255);
         end
      end

      // ---------------- register reset: R1
      begin_prog();
      put(8'h00, 16'h3180);
      put(8'h02, 16'h3681);
      put(8'h04, 16'h3782);
      put(8'h06, 16'hC000);
      go(cyc);
      peek(8'h80, v); chk("R1", "reg1 cleared", v, 0);
      peek(8'h81, v); chk("R1", "reg6 cleared", v, 0);
      peek(8'h82, v); chk("R1", "reg7 cleared", v, 0);

      // ---------------- rotate sweep: R6
      for (int s = 0; s < 2; s++) begin
         for (int k = 0; k < 16; k++) begin
            a = (s == 0) ? 8'hB4 : 8'h01;
            begin_prog();
            put(8'h00, 16'h2100 | a);
            put(8'h02, 16'hA100 | k);
            put(8'h04, 16'h3180);
            put(8'h06, 16'hC000);
            go(cyc);
            peek(8'h80, v); chk("R6", "rotate right", v, rot(a, k));
         end
      end

      // ---------------- loads, move, indirect store, no-ops: R3, R10, R12, R8
      begin_prog();
      put(8'h00, 16'h215A);
      put(8'h02, 16'h3190);
      put(8'h04, 16'h1290);
      put(8'h06, 16'h4F23);
      put(8'h08, 16'h24A0);
      put(8'h0A, 16'hE3F4);
      put(8'h0C, 16'h3391);
      put(8'h0E, 16'h0FFF);
      put(8'h10, 16'hFFFF);
      put(8'h12, 16'hC000);
      put(8'h14, 16'h3192);
      go(cyc);
      chk("R12", "cycles with no-ops", cyc, 30);
      peek(8'h90, v); chk("R3", "store of immediate", v, 8'h5A);
      peek(8'h91, v); chk("R3", "move then store", v, 8'h5A);
      peek(8'hA0, v); chk("R10", "indirect store", v, 8'h5A);
      peek(8'hFF, v); chk("R12", "no-op leaves memory", v, 8'hFF);
      chk("R8", "pc after halt", int'(pc), 8'h14);
      repeat (20) @(negedge clk);
      chk("R8", "halted held", int'(halted), 1);
      chk("R8", "pc frozen", int'(pc), 8'h14);
      peek(8'h92, v); chk("R8", "no store after halt", v, 8'hFF);

      // ---------------- jump taken with equal nonzero values: R7
      begin_prog();
      put(8'h00, 16'h2007);
      put(8'h02, 16'h2107);
      put(8'h04, 16'hB10A);
      put(8'h06, 16'h2233);
      put(8'h08, 16'hC000);
      put(8'h0A, 16'h3080);
      put(8'h0C, 16'hC000);
      go(cyc);
      peek(8'h80, v); chk("R7", "taken jump reaches store", v, 7);
      chk("R7", "pc after taken jump", int'(pc), 8'h0E);

      // ---------------- jump to 0xFE, fetch wraps, then not taken: R7, R2
      begin_prog();
      put(8'h00, 16'hB2FE);
      put(8'hFE, 16'h2201);
      put(8'h02, 16'h3280);
      put(8'h04, 16'hC000);
      go(cyc);
      chk("R2", "cycles across wrap", cyc, 15);
      peek(8'h80, v); chk("R7", "not-taken jump falls through", v, 1);
      chk("R2", "pc after wrap", int'(pc), 8'h06);

      // ---------------- wait lengths: R9
      for (int w = 0; w < 3; w++) begin
         a = (w == 0) ? 0 : ((w == 1) ? 2 : 19);
         begin_prog();
         put(8'h00, 16'hD000 | a);
         put(8'h02, 16'hC000);
         go(cyc);
         chk("R9", "wait cycles", cyc, 6 + a * CPM);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule